// File: doc/BRIEF.md
# Ramped Stereo Volume Attenuator

This block scales a stereo stream of signed audio samples by a per-channel volume level without ever letting the gain jump. Each channel keeps two 10-bit values: the level software has asked for, and the level actually applied. On every frame strobe, which marks one left/right sample pair, the applied level moves one step toward its target. A large volume change therefore becomes a smooth ramp instead of an audible click. Mute uses the same ramp: muting sets the target of both channels to zero, and unmuting lets the level climb back to the stored request.

Requests and a soft mute bit are loaded together through a one-cycle write strobe. A hardware mute pin is ORed with the soft mute bit. After reset the block passes audio unchanged, so it needs no configuration. Gain is linear, `sample * level / 1023`, rounded toward zero. The output registers update on the frame strobe, so both channels of a frame use the gain that was in force when that frame arrived.

Top module: `vol_ramp_atten`

## Requirements
- R1: After reset, both requests are 1023, soft mute is off, both applied levels are 1023 and both outputs are 0.
- R2: The applied level of a channel changes only on a cycle with `frame_stb` high. On such a cycle it moves exactly one step toward that channel's target.
- R3: An applied level that already equals its target stays unchanged on a frame strobe.
- R4: With the target at 0, a channel starting at 1023 reaches 0 after exactly 1023 frame strobes. With the target back at 1023, it reaches 1023 again after another 1023 strobes.
- R5: Left and right each have their own request and ramp. A request on one channel does not move the other channel.
- R6: Mute is active when `mute_pin` or the soft mute bit is 1. While mute is active, the target of both channels is 0. The stored requests are kept, and on unmute each level ramps back to its own request.
- R7: A request or mute value written in a cycle affects ramping from the first frame strobe in a later cycle. A frame strobe in the same cycle as the write still uses the previous values.
- R8: Each output equals `(sample * level) / 1023`, truncated toward zero. Level 1023 returns the sample unchanged and level 0 returns 0, including for negative samples.
- R9: Outputs load only on a frame strobe. They use the sample present at that strobe and the applied level held just before that strobe's step. Between strobes they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per stereo frame |
| in_left | input | SAMPLE_W | Left input sample, two's complement |
| in_right | input | SAMPLE_W | Right input sample, two's complement |
| req_wr | input | 1 | Loads both requests and the soft mute bit |
| req_left | input | LEVEL_W | Requested left level |
| req_right | input | LEVEL_W | Requested right level |
| req_mute | input | 1 | Soft mute value loaded by `req_wr` |
| mute_pin | input | 1 | Hardware mute, active high |
| out_left | output | SAMPLE_W | Attenuated left sample |
| out_right | output | SAMPLE_W | Attenuated right sample |
| level_left | output | LEVEL_W | Applied left level |
| level_right | output | LEVEL_W | Applied right level |

## Verification
The hardest cases to reach from the ports are the two ends of the ramp. Exactly 1023 steps must be counted from full level to silence and back again, and the applied level must never wrap past 0 or 1023. The bench gets there by muting through the soft bit and then issuing frames one at a time, comparing the applied level with its own model after every strobe. It also counts the strobes until each end is reached. A second hard case is a write that lands on the same clock edge as a frame strobe. The bench drives both strobes in the same cycle and expects the step to follow the old target.

// File: rtl/vra_pkg.sv
package vra_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/vra_level_ramp.sv
module vra_level_ramp
  import vra_pkg::*;
#(
  parameter int LEVEL_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_stb,
  input  logic [LEVEL_W-1:0] target,
  output logic [LEVEL_W-1:0] level,
  output logic               step_up,
  output logic               step_dn
);

  step_e dir;

  always_comb begin
    dir = STEP_HOLD;
    if (level < target)      dir = STEP_UP;
    else if (level > target) dir = STEP_DOWN;
  end

  assign step_up = frame_stb && (dir == STEP_UP);
  assign step_dn = frame_stb && (dir == STEP_DOWN);

  always_ff @(posedge clk) begin
    if (!rst_n)       level <= '1;
    else if (step_up) level <= level + LEVEL_W'(1);
    else if (step_dn) level <= level - LEVEL_W'(1);
  end

  logic [LEVEL_W:0] lvl_x;
  assign lvl_x = {1'b0, level};

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (lvl_x == $past(lvl_x)) ||
                  (lvl_x == $past(lvl_x) + (LEVEL_W+1)'(1)) ||
                  (lvl_x + (LEVEL_W+1)'(1) == $past(lvl_x)));

  // R2
  level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(level));

  // R2
  level_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (level < target)) |=> (level > $past(level)));

  // R3
  level_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (level == target)) |=> $stable(level));

endmodule

// File: rtl/vra_gain_stage.sv
module vra_gain_stage #(
  parameter int SAMPLE_W = 24,
  parameter int LEVEL_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic        [LEVEL_W-1:0]  level,
  output logic signed [SAMPLE_W-1:0] sample_out
);

  localparam int PROD_W = SAMPLE_W + LEVEL_W + 1;
  localparam int FULL   = (1 << LEVEL_W) - 1;

  // Linear gain: product over full scale, Verilog signed division truncates toward zero.
  function automatic logic signed [SAMPLE_W-1:0] scale(
    input logic signed [SAMPLE_W-1:0] s,
    input logic        [LEVEL_W-1:0]  lv
  );
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] q;
    p = PROD_W'(s) * $signed(PROD_W'(lv));
    q = p / $signed(PROD_W'(FULL));
    return q[SAMPLE_W-1:0];
  endfunction

  logic signed [SAMPLE_W-1:0] scaled;
  assign scaled = scale(sample_in, level);

  always_ff @(posedge clk) begin
    if (!rst_n)    sample_out <= '0;
    else if (load) sample_out <= scaled;
  end

  // R8
  unity_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (level == LEVEL_W'(FULL))) |=> (sample_out == $past(sample_in)));

  // R8
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (level == '0)) |=> (sample_out == '0));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sample_out));

endmodule

// File: rtl/vol_ramp_atten.sv
module vol_ramp_atten
  import vra_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int LEVEL_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_stb,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic                       req_wr,
  input  logic        [LEVEL_W-1:0]  req_left,
  input  logic        [LEVEL_W-1:0]  req_right,
  input  logic                       req_mute,
  input  logic                       mute_pin,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic        [LEVEL_W-1:0]  level_left,
  output logic        [LEVEL_W-1:0]  level_right
);

  logic [NUM_CH-1:0][LEVEL_W-1:0]  req_in;
  logic [NUM_CH-1:0][LEVEL_W-1:0]  req_q;
  logic [NUM_CH-1:0][LEVEL_W-1:0]  target;
  logic [NUM_CH-1:0][LEVEL_W-1:0]  level;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_in;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_out;
  logic [NUM_CH-1:0]               step_up;
  logic [NUM_CH-1:0]               step_dn;
  logic                            mute_q;
  logic                            muted;

  assign req_in[0] = req_left;
  assign req_in[1] = req_right;
  assign smp_in[0] = in_left;
  assign smp_in[1] = in_right;

  always_ff @(posedge clk) begin
    if (!rst_n)      mute_q <= 1'b0;
    else if (req_wr) mute_q <= req_mute;
  end

  assign muted = mute_pin | mute_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic signed [SAMPLE_W-1:0] gain_out;

    always_ff @(posedge clk) begin
      if (!rst_n)      req_q[ch] <= '1;
      else if (req_wr) req_q[ch] <= req_in[ch];
    end

    assign target[ch] = muted ? '0 : req_q[ch];

    vra_level_ramp #(.LEVEL_W(LEVEL_W)) i_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_stb(frame_stb),
      .target   (target[ch]),
      .level    (level[ch]),
      .step_up  (step_up[ch]),
      .step_dn  (step_dn[ch])
    );

    vra_gain_stage #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) i_gain (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_stb),
      .sample_in ($signed(smp_in[ch])),
      .level     (level[ch]),
      .sample_out(gain_out)
    );

    assign smp_out[ch] = gain_out;

    // R6
    mute_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && muted && (level[ch] != '0)) |=> (level[ch] == $past(level[ch]) - LEVEL_W'(1)));

    // R6
    mute_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (muted && (level[ch] == '0)) |=> (level[ch] == '0));
  end

  // R2
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up & step_dn) == '0);

  assign out_left    = $signed(smp_out[0]);
  assign out_right   = $signed(smp_out[1]);
  assign level_left  = level[0];
  assign level_right = level[1];

endmodule

// File: tb/test_vol_ramp_atten.sv
`timescale 1ns/1ps
module test_vol_ramp_atten;
  localparam int SW = 24;
  localparam int LW = 10;
  localparam int FULL = 1023;

  logic clk = 1'b0, rst_n = 1'b0, frame_stb = 1'b0, req_wr = 1'b0;
  logic req_mute = 1'b0, mute_pin = 1'b0;
  logic signed [SW-1:0] in_left = '0, in_right = '0;
  logic [LW-1:0] req_left = '1, req_right = '1;
  wire signed [SW-1:0] out_left, out_right;
  wire [LW-1:0] level_left, level_right;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_req [2];
  int m_lev [2];
  bit m_mute;
  longint m_out [2];

  vol_ramp_atten #(.SAMPLE_W(SW), .LEVEL_W(LW)) i_vol_ramp_atten (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .in_left(in_left), .in_right(in_right),
    .req_wr(req_wr), .req_left(req_left), .req_right(req_right),
    .req_mute(req_mute), .mute_pin(mute_pin),
    .out_left(out_left), .out_right(out_right),
    .level_left(level_left), .level_right(level_right)
  );

  always #2.5 clk = ~clk;

  function automatic longint scale(longint s, int lv);
    return (s * lv) / FULL;
  endfunction

  function automatic int step(int cur, int tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  task automatic check(string r, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic check_all(string r);
    check({r, " out_left"}, out_left, m_out[0]);
    check({r, " out_right"}, out_right, m_out[1]);
    check({r, " level_left"}, level_left, m_lev[0]);
    check({r, " level_right"}, level_right, m_lev[1]);
  endtask

  task automatic model_frame(longint l, longint r);
    m_out[0] = scale(l, m_lev[0]);
    m_out[1] = scale(r, m_lev[1]);
    for (int c = 0; c < 2; c++)
      m_lev[c] = step(m_lev[c], (m_mute || mute_pin) ? 0 : m_req[c]);
  endtask

  task automatic frame(longint l, longint r, string tag);
    @(negedge clk);
    in_left = l[SW-1:0]; in_right = r[SW-1:0]; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    model_frame(l, r);
    check_all(tag);
  endtask

  task automatic write(int l, int r, bit m);
    @(negedge clk);
    req_left = LW'(l); req_right = LW'(r); req_mute = m; req_wr = 1'b1;
    @(negedge clk);
    req_wr = 1'b0;
    m_req[0] = l; m_req[1] = r; m_mute = m;
  endtask

  task automatic t_reset;
    check("R1 out_left", out_left, 0);
    check("R1 out_right", out_right, 0);
    check("R1 level_left", level_left, FULL);
    check("R1 level_right", level_right, FULL);
  endtask

  task automatic t_passthrough;
    frame(8388607, -8388608, "R8 unity extremes");
    frame(-1, 1, "R8 unity small");
    frame(123456, -654321, "R1 default passthrough");
  endtask

  task automatic t_hold;
    @(negedge clk); in_left = 24'sd777; in_right = -24'sd999;
    repeat (3) @(negedge clk);
    check_all("R9 hold between strobes");
  endtask

  task automatic t_ramp_partial;
    write(1020, 1023, 0);
    for (int i = 0; i < 5; i++) frame(1000 * i, -2000 * i, "R2 R5 partial ramp");
    check("R3 left settled", level_left, 1020);
    check("R5 right untouched", level_right, 1023);
  endtask

  task automatic t_truncation;
    frame(1000, -5, "R8 truncation");
    frame(-1000, 5, "R8 truncation neg");
    check("R8 997", out_left, -997);
    check("R8 unity -> 5", out_right, 5);
  endtask

  task automatic t_pin_mute;
    @(negedge clk); mute_pin = 1'b1;
    for (int i = 0; i < 3; i++) frame(500, 500, "R6 pin mute ramp");
    check("R6 left down", level_left, 1017);
    @(negedge clk); mute_pin = 1'b0;
    for (int i = 0; i < 4; i++) frame(500, 500, "R6 unmute ramp");
    check("R6 request kept", level_left, 1020);
  endtask

  task automatic t_full_swing;
    int n;
    write(1023, 1023, 1);
    n = 0;
    while (level_right != 0 && n < 1100) begin
      frame(n * 777 - 400000, 400000 - n * 777, "R4 swing down");
      n++;
    end
    check("R4 frames to zero", n, 1023);
    frame(8388607, -8388608, "R8 zero level");
    check("R8 zero out", out_left, 0);
    write(1023, 1023, 0);
    n = 0;
    while (level_right != 1023 && n < 1100) begin
      frame(n * 333 - 100000, n * 5, "R4 swing up");
      n++;
    end
    check("R4 frames to full", n, 1023);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_left = '0; req_right = '0; req_mute = 1'b0;
    req_wr = 1'b1; frame_stb = 1'b1; in_left = 24'sd4000; in_right = 24'sd8;
    @(negedge clk);
    req_wr = 1'b0; frame_stb = 1'b0;
    model_frame(4000, 8);
    m_req[0] = 0; m_req[1] = 0;
    check_all("R7 same-cycle write");
    check("R7 old target kept", level_left, 1023);
    frame(4000, 8, "R7 next strobe");
    check("R7 new target applied", level_left, 1022);
  endtask

  initial begin
    m_req[0] = FULL; m_req[1] = FULL; m_lev[0] = FULL; m_lev[1] = FULL;
    m_mute = 0; m_out[0] = 0; m_out[1] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_passthrough;
    t_hold;
    t_ramp_partial;
    t_truncation;
    t_pin_mute;
    t_full_swing;
    t_same_cycle;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule